// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is the clocked control core of a synchronous buck gate driver. It receives one PWM command that external comparators have already reduced to three levels (low, high, or a middle "float" window) and produces two enables: one for the high-side switch gate and one for the low-side switch gate. It never enables one gate until a feedback comparator reports that the other gate has discharged below its turn-off threshold. The dead time therefore follows the real gate discharge instead of a fixed count.

A PWM command that stays in the middle window for a programmable hold-off period shuts the stage down. In that state both gates are held off until the command leaves the window. When forced-continuous mode is deselected, the block emulates a diode. An inductor zero-current flag ends the low-side conduction early, but only after a minimum on-time. The stage then stays parked off until the next high command. A supply-good flag overrides everything else and returns the sequencer to idle.

Top module: `gate_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, both `hs_en` and `ls_en` are low. `pwm_lvl` is encoded as follows: 2'b00 is low, 2'b01 is high, and 2'b10 or 2'b11 is the middle window.
- R2: On a change to high, `ls_en` drops on the first clock edge. `hs_en` rises one clock after `ls_gate_low` is sampled high with the command still high. While `ls_gate_low` stays low, `hs_en` stays low.
- R3: On a change to low, `hs_en` drops on the first clock edge. `ls_en` rises one clock after `hs_gate_low` is sampled high with the command still low. While `hs_gate_low` stays low, `ls_en` stays low.
- R4: `hs_en` and `ls_en` are never high in the same cycle.
- R5: A middle-window command held for HOLD_CYC consecutive samples drives both enables low on that HOLD_CYC-th edge. A middle-window excursion shorter than HOLD_CYC samples leaves the enables unchanged.
- R6: Once in shutdown, both enables stay low while the command remains in the window. Leaving the window restarts the normal break-before-make sequence toward the new level.
- R7: With `fccm` low and `ls_en` high, a sampled `zero_i` drops `ls_en`. It then stays low until the command goes high.
- R8: In that mode, `ls_en` is high for at least LS_MIN_CYC cycles before a zero-current turn-off takes effect. With `zero_i` already high at turn-on, it is high for exactly LS_MIN_CYC cycles.
- R9: With `fccm` high, `zero_i` has no effect, and `ls_en` stays high for as long as the command stays low.
- R10: `fccm` acts on the cycle it is sampled, whatever the point in the PWM period. Lowering it while the low side has been on at least LS_MIN_CYC cycles and `zero_i` is high turns `ls_en` off on the next edge. Raising it while the low side is parked off re-enables `ls_en` through the normal wait for `hs_gate_low`.
- R11: While `supply_ok` is low, both enables are low on the next edge and the sequencer is idle. After `supply_ok` returns, a high command still passes through the wait state, so `hs_en` rises on the second edge.
- R12: If the command returns to its previous level while a turn-on waits for its gate flag, the pending turn-on is cancelled, and the newly requested gate is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Bias supply good; low forces both gates off |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 1x middle window |
| hs_gate_low | input | 1 | High-side gate-to-source voltage is below turn-off threshold |
| ls_gate_low | input | 1 | Low-side gate voltage is below turn-off threshold |
| zero_i | input | 1 | Inductor current has reached zero |
| fccm | input | 1 | 1 forces continuous conduction; 0 allows diode emulation |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench holds each gate-discharge flag low on purpose to prove that the opposite gate waits. A design with a fixed dead time would turn on early and overlap. It measures the hold-off window to the exact cycle from both sides: one sample short must leave the gate on, and an off-by-one counter would shut down one cycle early or late. It times the minimum on-time against a zero-current flag that is already asserted, and toggles the mode select while the low side is on and while it is parked. This exposes designs that latch the mode per period or ignore the minimum. A glitch back to the old level during a dead-time wait must not enable the newly requested gate, which a design that completes pending turn-ons would do.

// File: rtl/gate_seq.sv
module gate_seq #(
  parameter int HOLD_CYC   = 16,
  parameter int LS_MIN_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic [1:0] pwm_lvl,
  input  logic       hs_gate_low,
  input  logic       ls_gate_low,
  input  logic       zero_i,
  input  logic       fccm,
  output logic       hs_en,
  output logic       ls_en
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int LW = $clog2(LS_MIN_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
  localparam logic [HW-1:0] HOLD_SAT  = HW'(HOLD_CYC);
  localparam logic [LW-1:0] LS_LAST   = LW'(LS_MIN_CYC - 1);
  localparam logic [LW-1:0] LS_SAT    = LW'(LS_MIN_CYC);

  typedef enum logic [2:0] {IDLE, WAIT_HS, HS_ON, WAIT_LS, LS_ON, LS_PARK, SHUT} st_t;

  st_t st, nxt;
  logic [HW-1:0] mid_cnt;
  logic [LW-1:0] ls_cnt;

  wire is_high = (pwm_lvl == 2'b01);
  wire is_mid  = pwm_lvl[1];
  wire dcm_off = !fccm && zero_i && (ls_cnt >= LS_LAST);

  always_comb begin
    nxt = st;
    if (!supply_ok) nxt = IDLE;
    else if (is_mid) begin
      if (st == SHUT || mid_cnt == HOLD_LAST) nxt = SHUT;
    end else begin
      case (st)
        IDLE, SHUT: nxt = is_high ? WAIT_HS : WAIT_LS;
        WAIT_HS:    if (!is_high) nxt = WAIT_LS; else if (ls_gate_low) nxt = HS_ON;
        HS_ON:      if (!is_high) nxt = WAIT_LS;
        WAIT_LS:    if (is_high) nxt = WAIT_HS; else if (hs_gate_low) nxt = LS_ON;
        LS_ON:      if (is_high) nxt = WAIT_HS; else if (dcm_off) nxt = LS_PARK;
        LS_PARK:    if (is_high) nxt = WAIT_HS; else if (fccm) nxt = WAIT_LS;
        default:    nxt = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      mid_cnt <= '0;
      ls_cnt  <= '0;
    end else begin
      st      <= nxt;
      mid_cnt <= !is_mid ? '0 : (mid_cnt == HOLD_SAT ? mid_cnt : mid_cnt + 1'b1);
      ls_cnt  <= (st != LS_ON) ? '0 : (ls_cnt == LS_SAT ? ls_cnt : ls_cnt + 1'b1);
    end
  end

  assign hs_en = (st == HS_ON);
  assign ls_en = (st == LS_ON);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  p_hs_after_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(ls_gate_low) && $past(is_high));

  p_ls_after_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(hs_gate_low) && $past(pwm_lvl) == 2'b00);

  p_supply_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !hs_en && !ls_en);

  p_ccm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en && fccm && supply_ok && pwm_lvl == 2'b00) |=> ls_en);

  p_min_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ls_en) && $past(pwm_lvl) == 2'b00 && $past(supply_ok)) |-> $past(ls_cnt) >= LS_LAST);

  p_shut_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && is_mid && mid_cnt == HOLD_LAST) |=> !hs_en && !ls_en);
endmodule

// File: tb/sim_gate_seq.sv
module sim_gate_seq;
  localparam int HOLD = 16;
  localparam int LMIN = 40;

  logic clk = 0, rst_n = 0, supply_ok = 1, zero_i = 0, fccm = 1;
  logic [1:0] pwm_lvl = 2'b00;
  logic auto_fb = 1, hs_man = 1, ls_man = 1, hs_auto = 1, ls_auto = 1;
  logic hs_en, ls_en;
  int n_run = 0, n_fail = 0, n_overlap = 0;

  wire hs_gate_low = auto_fb ? hs_auto : hs_man;
  wire ls_gate_low = auto_fb ? ls_auto : ls_man;

  gate_seq #(.HOLD_CYC(HOLD), .LS_MIN_CYC(LMIN)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwm_lvl(pwm_lvl),
    .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low), .zero_i(zero_i),
    .fccm(fccm), .hs_en(hs_en), .ls_en(ls_en));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    hs_auto <= !hs_en;
    ls_auto <= !ls_en;
    if (hs_en && ls_en) n_overlap++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reach_ls_on();
    auto_fb = 1; fccm = 1; zero_i = 0; pwm_lvl = 2'b00;
    tick(4);
  endtask

  task automatic reach_hs_on();
    auto_fb = 1; pwm_lvl = 2'b01;
    tick(4);
  endtask

  task automatic t_reset();
    chk("R1 reset hs", hs_en, 0);
    chk("R1 reset ls", ls_en, 0);
  endtask

  task automatic t_rise();
    int early = 0;
    reach_ls_on();
    chk("R3 start ls", ls_en, 1);
    auto_fb = 0; hs_man = 1; ls_man = 0; pwm_lvl = 2'b01;
    tick(1);
    chk("R2 ls drops first", ls_en, 0);
    for (int i = 0; i < 6; i++) begin tick(1); if (hs_en) early++; end
    chk("R2 hs waits for flag", early, 0);
    ls_man = 1;
    tick(1);
    chk("R2 hs after flag", hs_en, 1);
  endtask

  task automatic t_fall();
    int early = 0;
    hs_man = 0; ls_man = 1; pwm_lvl = 2'b00;
    tick(1);
    chk("R3 hs drops first", hs_en, 0);
    for (int i = 0; i < 6; i++) begin tick(1); if (ls_en) early++; end
    chk("R3 ls waits for flag", early, 0);
    hs_man = 1;
    tick(1);
    chk("R3 ls after flag", ls_en, 1);
  endtask

  task automatic t_glitch();
    int bad = 0;
    reach_ls_on();
    auto_fb = 0; hs_man = 1; ls_man = 0; pwm_lvl = 2'b01;
    tick(1);
    pwm_lvl = 2'b00; ls_man = 1;
    for (int i = 0; i < 3; i++) begin tick(1); if (hs_en) bad++; end
    chk("R12 cancelled hs never on", bad, 0);
    chk("R12 ls restored", ls_en, 1);
    auto_fb = 1;
  endtask

  task automatic t_holdoff();
    int drop = 0;
    reach_hs_on();
    pwm_lvl = 2'b10;
    for (int i = 0; i < HOLD - 1; i++) begin tick(1); if (!hs_en) drop++; end
    pwm_lvl = 2'b01;
    tick(1);
    chk("R5 short window no effect", drop, 0);
    chk("R5 short window hs on", hs_en, 1);
    pwm_lvl = 2'b11;
    tick(HOLD - 1);
    chk("R5 hs on before hold-off", hs_en, 1);
    tick(1);
    chk("R5 hs off at hold-off", hs_en, 0);
    chk("R5 ls off at hold-off", ls_en, 0);
    tick(20);
    chk("R6 held off hs", hs_en, 0);
    chk("R6 held off ls", ls_en, 0);
    pwm_lvl = 2'b00;
    tick(1);
    chk("R6 exit waits", ls_en, 0);
    tick(1);
    chk("R6 exit to low", ls_en, 1);
  endtask

  task automatic t_dcm();
    reach_hs_on();
    fccm = 0; zero_i = 1; pwm_lvl = 2'b00;
    tick(2);
    chk("R8 ls on", ls_en, 1);
    tick(LMIN - 1);
    chk("R8 ls on at min", ls_en, 1);
    tick(1);
    chk("R8 ls off after min", ls_en, 0);
    tick(10);
    chk("R7 parked off", ls_en, 0);
    pwm_lvl = 2'b01;
    tick(2);
    chk("R7 next high", hs_en, 1);
    zero_i = 0; pwm_lvl = 2'b00;
    tick(LMIN + 20);
    chk("R7 no zero stays on", ls_en, 1);
    zero_i = 1;
    tick(1);
    chk("R7 zero turns off", ls_en, 0);
  endtask

  task automatic t_ccm();
    int off = 0;
    reach_ls_on();
    zero_i = 1;
    for (int i = 0; i < 100; i++) begin tick(1); if (!ls_en) off++; end
    chk("R9 zero ignored", off, 0);
    fccm = 0;
    tick(1);
    chk("R10 lower fccm acts", ls_en, 0);
    fccm = 1;
    tick(1);
    chk("R10 raise fccm wait", ls_en, 0);
    tick(1);
    chk("R10 raise fccm resume", ls_en, 1);
    zero_i = 0;
  endtask

  task automatic t_supply();
    int on = 0;
    reach_hs_on();
    supply_ok = 0;
    tick(1);
    chk("R11 supply off hs", hs_en, 0);
    for (int i = 0; i < 5; i++) begin tick(1); if (hs_en || ls_en) on++; end
    chk("R11 held off", on, 0);
    supply_ok = 1;
    tick(1);
    chk("R11 restart from idle", hs_en, 0);
    tick(1);
    chk("R11 restart hs", hs_en, 1);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick(2);
    t_rise();
    t_fall();
    t_glitch();
    t_holdoff();
    t_dcm();
    t_ccm();
    t_supply();
    chk("R4 overlap cycles", n_overlap, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule